// File: doc/BRIEF.md
# Serial Input-State Shifter with Parity and Stop Bits

This block is the logic side of an eight-channel digital input front end. When the host pulls chip select low, the block copies a snapshot of eight filtered input levels and a set of status bits into a shift register. It then shifts that snapshot out, most significant bit first, in SPI mode 0. The status bits are two active-low alarms, four even-parity flags over overlapping groups of inputs, and a pair of stop bits. A strap pin selects a short 8-bit frame with the inputs only, or a full 16-bit frame. Bits received on the serial input enter the register from the low end, so several devices can be chained with one chip select.

The serial output pin has an enable and a complemented twin. Both are released while chip select is high. If the power-good signal drops during a transfer, the output is held low. The host then reads the final stop bit as 0, which tells it that power was lost. The serial pins and the power-good signal are asynchronous. Each one passes through a synchronizer clocked by a system clock at least four times faster than the serial clock.

Top module: `spi_state_serializer`

## Requirements
- R1: When the synchronized chip select falls, the register loads a fresh frame, and its most significant bit appears on `so_o` before the first serial clock edge.
- R2: While selected, serial input is captured on each rising `sck_i` edge and the register shifts by one on each falling edge, so bit 15 goes out first.
- R3: In the 16-bit frame, bits 15..8 carry inputs 8..1 (input 8 is bit 15). Bit 7 is the under-voltage alarm and bit 6 is the over-temperature alarm. Bits 5..2 are parity flags A, B, C, D. Bit 1 is a 0 stop bit and bit 0 is a 1 stop bit, sent last.
- R4: Each parity flag is 1 when its group holds an even number of ones. Flag A covers all eight inputs, flag B covers inputs 5..8, flag C covers inputs 1..4 and flag D covers inputs 3..6.
- R5: `short_frame_i` = 1 selects the 8-bit frame, which carries inputs 8..1 only. The pin is taken only while chip select is high, so a change during a transfer has no effect until the next one.
- R6: While chip select is high, `so_en_o` is 0 (both outputs high-impedance) and activity on `sck_i` and `mosi_i` has no effect.
- R7: While enabled, `so_n_o` is always the inverse of `so_o`.
- R8: While `por_n_i` is 0 and chip select is low, `so_o` is 0 and `so_n_o` is 1, so the final stop bit reads 0.
- R9: If clocking continues past the frame length, the bits received on `mosi_i` appear on `so_o` after exactly 16 clocks (16-bit frame) or 8 clocks (8-bit frame).
- R10: The alarm inputs are sent as given (active low) and do not stop or change the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock (idle low) |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in (daisy-chain input) |
| short_frame_i | input | 1 | Frame length strap: 1 = 8-bit, 0 = 16-bit |
| por_n_i | input | 1 | Power good, low on power loss |
| in_state_i | input | 8 | Filtered input levels, bit 0 = input 1 |
| uv_alarm_n_i | input | 1 | Under-voltage alarm, active low |
| ot_alarm_n_i | input | 1 | Over-temperature alarm, active low |
| so_o | output | 1 | Serial data out |
| so_n_o | output | 1 | Complemented serial data out |
| so_en_o | output | 1 | Output enable for both data pins (0 = high-impedance) |

## Verification
Assertions check the following on every cycle: outputs stay released while chip select is high, the complement pin tracks the data pin, the output reads 0 under power loss, the frame-length mode holds steady during a transfer, the register shifts correctly in 16-bit mode, and a freshly loaded frame meets full-byte parity. Other behaviour needs the bench scenarios. These cover the exact bit order and the parity flags across all 256 input patterns, the 8-bit frame, and daisy-chain pass-through after 16 and 8 clocks. They also cover a mode change during a transfer having no effect, and serial activity while deselected being ignored.

// File: rtl/sser_pkg.sv
package sser_pkg;
  localparam int NUM_IN      = 8;
  localparam int FRAME_LONG  = 16;
  localparam int FRAME_SHORT = NUM_IN;
  localparam int MSB         = FRAME_LONG - 1;

  // Even-parity flag: 1 when the number of ones is even
  function automatic logic even_flag(input logic [NUM_IN-1:0] v,
                                     input logic [NUM_IN-1:0] mask);
    return ~(^(v & mask));
  endfunction
endpackage

// File: rtl/sser_sync.sv
module sser_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sser_edge.sv
module sser_edge #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) prev_q[g] <= RST_VAL[g];
        else     prev_q[g] <= lvl_i[g];
      end
      assign rise_o[g] = lvl_i[g] & ~prev_q[g];
      assign fall_o[g] = ~lvl_i[g] & prev_q[g];
    end
  endgenerate
endmodule

// File: rtl/sser_frame.sv
module sser_frame
  import sser_pkg::*;
(
  input  logic [NUM_IN-1:0]     in_state_i,
  input  logic                  uv_n_i,
  input  logic                  ot_n_i,
  output logic [FRAME_LONG-1:0] frame_o
);
  logic [NUM_IN-1:0] data_rev;
  logic pa, pb, pc, pd;

  // Input 8 lands on the most significant position
  genvar g;
  generate
    for (g = 0; g < NUM_IN; g++) begin : g_rev
      assign data_rev[g] = in_state_i[g];
    end
  endgenerate

  always_comb begin
    pa = even_flag(in_state_i, 8'hFF);
    pb = even_flag(in_state_i, 8'hF0);
    pc = even_flag(in_state_i, 8'h0F);
    pd = even_flag(in_state_i, 8'h3C);
    frame_o = {data_rev, uv_n_i, ot_n_i, pa, pb, pc, pd, 1'b0, 1'b1};
  end
endmodule

// File: rtl/sser_shifter.sv
module sser_shifter
  import sser_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_s_i,
  input  logic                  cs_fall_i,
  input  logic                  cs_rise_i,
  input  logic                  sck_rise_i,
  input  logic                  sck_fall_i,
  input  logic                  mosi_s_i,
  input  logic                  short_s_i,
  input  logic [FRAME_LONG-1:0] frame_i,
  output logic                  active_o,
  output logic                  msb_o
);
  logic [FRAME_LONG-1:0] shreg_q;
  logic active_q, mode_short_q, mosi_cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q      <= '0;
      active_q     <= 1'b0;
      mode_short_q <= 1'b0;
      mosi_cap_q   <= 1'b0;
    end else begin
      if (!active_q && cs_s_i) mode_short_q <= short_s_i;
      if (cs_fall_i) begin
        shreg_q  <= frame_i;
        active_q <= 1'b1;
      end else if (cs_rise_i) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        if (sck_rise_i) mosi_cap_q <= mosi_s_i;
        if (sck_fall_i) begin
          if (mode_short_q)
            shreg_q[MSB -: FRAME_SHORT] <= {shreg_q[MSB-1 -: FRAME_SHORT-1], mosi_cap_q};
          else
            shreg_q <= {shreg_q[MSB-1:0], mosi_cap_q};
        end
      end
    end
  end

  assign active_o = active_q;
  assign msb_o    = shreg_q[MSB];

  // R5: mode latch frozen for the whole transfer
  p_mode_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (active_q && $past(active_q)) |-> $stable(mode_short_q));

  // R2: one-place shift on a falling serial clock in the long frame
  p_shift_step_r2: assert property (@(posedge clk) disable iff (rst)
    (active_q && sck_fall_i && !cs_fall_i && !cs_rise_i && !mode_short_q)
      |=> (shreg_q[MSB:1] == $past(shreg_q[MSB-1:0])));

  // R4: a freshly loaded frame meets full-byte even parity
  p_load_parity_r4: assert property (@(posedge clk) disable iff (rst)
    $past(cs_fall_i) |-> ((shreg_q[5] ^ (^shreg_q[MSB -: NUM_IN])) == 1'b1));

  // R6: register untouched while deselected
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !cs_fall_i) |=> $stable(shreg_q));
endmodule

// File: rtl/spi_state_serializer.sv
module spi_state_serializer
  import sser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  input  logic              short_frame_i,
  input  logic              por_n_i,
  input  logic [NUM_IN-1:0] in_state_i,
  input  logic              uv_alarm_n_i,
  input  logic              ot_alarm_n_i,
  output logic              so_o,
  output logic              so_n_o,
  output logic              so_en_o
);
  localparam int NSYNC = 5;
  // order: {por_n, short, mosi, cs, sck}
  localparam logic [NSYNC-1:0] SYNC_RST = 5'b10010;

  logic [NSYNC-1:0] raw, syn;
  logic sck_s, cs_s, mosi_s, short_s, por_s;
  logic [1:0] rise, fall;
  logic [FRAME_LONG-1:0] frame;
  logic active, msb;

  assign raw = {por_n_i, short_frame_i, mosi_i, csn_i, sck_i};

  sser_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(syn));

  assign {por_s, short_s, mosi_s, cs_s, sck_s} = syn;

  sser_edge #(.W(2), .RST_VAL(2'b10)) edge_i (
    .clk(clk), .rst(rst), .lvl_i({cs_s, sck_s}), .rise_o(rise), .fall_o(fall));

  sser_frame frame_i (
    .in_state_i(in_state_i), .uv_n_i(uv_alarm_n_i), .ot_n_i(ot_alarm_n_i),
    .frame_o(frame));

  sser_shifter shift_i (
    .clk(clk), .rst(rst), .cs_s_i(cs_s),
    .cs_fall_i(fall[1]), .cs_rise_i(rise[1]),
    .sck_rise_i(rise[0]), .sck_fall_i(fall[0]),
    .mosi_s_i(mosi_s), .short_s_i(short_s), .frame_i(frame),
    .active_o(active), .msb_o(msb));

  always_comb begin
    so_en_o = active;
    so_o    = active & por_s & msb;
    so_n_o  = active & ~so_o;
  end

  // R6: released whenever chip select has been high for two samples
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (cs_s && $past(cs_s)) |-> !so_en_o);

  // R7: complement pin tracks data pin while driven
  p_complement_r7: assert property (@(posedge clk) disable iff (rst)
    so_en_o |-> (so_n_o != so_o));

  // R8: power loss forces a low data pin
  p_powerloss_r8: assert property (@(posedge clk) disable iff (rst)
    (so_en_o && !por_s) |-> (!so_o && so_n_o));
endmodule

// File: tb/spi_state_serializer_tb_top.sv
module spi_state_serializer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, short_fr = 1'b0, por_n = 1'b1;
  logic [7:0] ins = '0;
  logic uvn = 1'b1, otn = 1'b1;
  logic so, so_n, so_en;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  spi_state_serializer dut_i (
    .clk(clk), .rst(rst), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .short_frame_i(short_fr), .por_n_i(por_n), .in_state_i(ins),
    .uv_alarm_n_i(uvn), .ot_alarm_n_i(otn),
    .so_o(so), .so_n_o(so_n), .so_en_o(so_en));

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_frame(input logic [7:0] v, input logic u,
                                            input logic o);
    logic pa, pb, pc, pd;
    int n;
    n = 0; for (int i = 0; i < 8; i++) n += v[i];
    pa = (n % 2) == 0;
    n = 0; for (int i = 4; i < 8; i++) n += v[i];
    pb = (n % 2) == 0;
    n = 0; for (int i = 0; i < 4; i++) n += v[i];
    pc = (n % 2) == 0;
    n = 0; for (int i = 2; i < 6; i++) n += v[i];
    pd = (n % 2) == 0;
    return {v, u, o, pa, pb, pc, pd, 1'b0, 1'b1};
  endfunction

  // Runs one selected transfer of nbits clocks; rd holds bits read MSB first
  task automatic xfer(input int nbits, input logic [31:0] tx,
                      output logic [31:0] rd, output bit comp_ok);
    rd = '0; comp_ok = 1'b1;
    csn = 1'b0; wclk(8);
    for (int i = 0; i < nbits; i++) begin
      rd[nbits-1-i] = so;
      if (!(so_en && so_n == ~so)) comp_ok = 1'b0;
      mosi = tx[nbits-1-i]; wclk(2);
      sck = 1'b1; wclk(8);
      sck = 1'b0; wclk(8);
    end
    csn = 1'b1; wclk(8);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] ef;
    bit cok;
    wclk(4); rst = 1'b0; wclk(6);
    check(so_en == 1'b0 && so == 1'b0, "R6 reset idle", {so_en, so}, 0);

    // R1 R2 R3 R4 R7 R10: all input patterns, 16-bit frame
    for (int p = 0; p < 256; p++) begin
      ins = p[7:0]; uvn = p[2] ^ p[5]; otn = p[7] ^ p[0];
      ef = exp_frame(ins, uvn, otn);
      xfer(16, 32'h0, rd, cok);
      check(rd[15:0] == ef, "R3 R4 R10 frame", rd, ef);
      check(cok, "R7 complement", cok, 1);
    end

    // R5: 8-bit frame
    short_fr = 1'b1; wclk(6);
    for (int p = 0; p < 16; p++) begin
      ins = 8'(p * 29 + 3);
      xfer(8, 32'h0, rd, cok);
      check(rd[7:0] == ins, "R5 short frame", rd, ins);
    end

    // R9: daisy chain in 8-bit mode
    ins = 8'hC5;
    xfer(16, 32'h00003A00, rd, cok);
    check(rd[15:0] == {8'hC5, 8'h3A}, "R9 pass-through 8", rd, {8'hC5, 8'h3A});

    // R9: daisy chain in 16-bit mode
    short_fr = 1'b0; wclk(6);
    ins = 8'h96; uvn = 1'b0; otn = 1'b1;
    ef = exp_frame(ins, uvn, otn);
    xfer(32, 32'hBEEF0000, rd, cok);
    check(rd == {ef, 16'hBEEF}, "R9 pass-through 16", rd, {ef, 16'hBEEF});

    // R5: mode pin change mid-transfer has no effect
    ins = 8'h5A; uvn = 1'b1; otn = 1'b0;
    ef = exp_frame(ins, uvn, otn);
    csn = 1'b0; wclk(8);
    short_fr = 1'b1; wclk(8);
    rd = '0;
    for (int i = 0; i < 32; i++) begin
      rd[31-i] = so;
      mosi = 1'b1; wclk(2);
      sck = 1'b1; wclk(8); sck = 1'b0; wclk(8);
    end
    csn = 1'b1; wclk(8);
    check(rd == {ef, 16'hFFFF}, "R5 mode frozen", rd, {ef, 16'hFFFF});
    short_fr = 1'b0; wclk(6);

    // R6: serial activity while deselected
    for (int i = 0; i < 6; i++) begin
      mosi = i[0]; sck = 1'b1; wclk(8);
      check(so_en == 1'b0, "R6 hi-z while deselected", so_en, 0);
      sck = 1'b0; wclk(8);
    end
    ins = 8'h01; ef = exp_frame(ins, uvn, otn);
    xfer(16, 32'h0, rd, cok);
    check(rd[15:0] == ef, "R6 ignored clocks", rd, ef);

    // R1: MSB visible right after select
    ins = 8'h80; csn = 1'b0; wclk(8);
    check(so == 1'b1 && so_en, "R1 first bit", so, 1);
    csn = 1'b1; wclk(8);

    // R8: power loss
    por_n = 1'b0; ins = 8'hFF; wclk(6);
    xfer(16, 32'h0, rd, cok);
    check(rd[15:0] == 16'h0, "R8 forced low", rd, 0);
    check(cok, "R8 complement high", cok, 1);
    por_n = 1'b1; wclk(6);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule